// File: doc/BRIEF.md
# Fault-Injectable Test RAM

This block is a small single-port RAM, one bit wide, that can be set up to misbehave in one chosen way. It serves as the device under test for memory self-test logic. A march engine or similar test sequencer drives it like ordinary storage, and the designer can confirm that each functional fault model is caught.

The fault setup has four parts: a kind code, a victim address, an aggressor address and two polarity bits. It is captured only while the synchronous reset `rst` is high. After reset, changes on those inputs are ignored until the next reset. At most one fault is active at a time. Kind code zero, and any unused code, gives a healthy memory.

Reads are registered. The value appears on `rdData` one cycle after the read request and then holds until the next accepted read. A read request in the same cycle as a write is dropped and the write proceeds. All cells clear to 0 during reset, except where a fault defines another start value for the victim.

Top module: `fault_ram`

## Requirements
- R1: While `rst` is high, `rdData` is 0 and every cell is cleared to 0 (except a victim preset by R3 or R6). After reset, a read with `re`=1 and `we`=0 places the cell value on `rdData` at the next clock edge. `rdData` holds its value in every cycle without an accepted read.
- R2: With kind 0, every cell stores and returns what was last written to it. When `re` and `we` are both 1, the write is performed, the read is dropped and `rdData` keeps its previous value.
- R3: Kind 1 (stuck): the victim always holds and returns `faultPol[0]`, from reset onward, whatever is written to it.
- R4: Kind 2 (transition): the victim cannot change towards the value `faultPol[0]`. So `faultPol[0]`=1 blocks 0 to 1, and `faultPol[0]`=0 blocks 1 to 0. Changes in the other direction work.
- R5: Kind 3 (stuck-open): writes to the victim have no effect, and a read of the victim leaves `rdData` at the value of the previous read.
- R6: Kind 4 (state coupling): whenever the aggressor cell holds `faultPol[1]`, the victim is held at `faultPol[0]`. This includes right after reset when `faultPol[1]` is 0.
- R7: Kind 5 (inversion coupling): a write that changes the aggressor to the value `faultPol[1]` complements the victim. A change in the other direction, or a write that leaves the aggressor unchanged, does not.
- R8: Kind 6 (idempotent coupling): a write that changes the aggressor to the value `faultPol[1]` sets the victim to `faultPol[0]`. A change in the other direction, or a write that leaves the aggressor unchanged, does not.
- R9: Kind 7 (read disturb): a read of the victim returns its stored value, and the stored value is inverted afterwards.
- R10: Kind 8 (decoder, no cell): a write to the victim address changes no cell, and a read of it returns 0.
- R11: Kind 9 (decoder, two cells): a write to the victim address updates both the victim cell and the aggressor cell. A read of the victim address returns the AND of the two cells. The aggressor address alone accesses only its own cell.
- R12: The fault inputs are sampled only while `rst` is high. Their values after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also the fault-capture window |
| addr | input | ADDR_W | Word address for read or write |
| we | input | 1 | Write request |
| re | input | 1 | Read request |
| wrData | input | 1 | Data to write |
| rdData | output | 1 | Registered read data |
| faultSel | input | 4 | Fault kind code (0 = healthy) |
| victimAddr | input | ADDR_W | Cell that the fault corrupts |
| aggrAddr | input | ADDR_W | Coupling cell, or second cell for kind 9 |
| faultPol | input | 2 | Bit 0: stuck/forced value or blocked target; bit 1: aggressor state or trigger direction |

## Verification
The hardest cases to reach are the coupling faults, because the victim changes only when a write to a different cell makes a specific transition. The bench first writes the aggressor to the opposite value and then writes it again. It also repeats a write of the same value to show that a non-transition leaves the victim alone. For state coupling with aggressor state 0, the victim must already read as forced right after reset, so the bench reads it before any write. Stuck-open needs a known earlier read value, so the bench reads a neighbouring cell holding the opposite value just before reading the victim.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;

  typedef enum logic [3:0] {
    FK_NONE  = 4'd0,
    FK_STUCK = 4'd1,
    FK_TRANS = 4'd2,
    FK_OPEN  = 4'd3,
    FK_STATE = 4'd4,
    FK_INV   = 4'd5,
    FK_IDEM  = 4'd6,
    FK_RDIST = 4'd7,
    FK_ANONE = 4'd8,
    FK_ALIAS = 4'd9
  } faultKind_e;

  typedef enum logic [2:0] {
    CM_NONE,
    CM_STUCK,
    CM_TRANS,
    CM_STATE,
    CM_INV,
    CM_IDEM
  } cellMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      wrMain;     // write addressed cell
    logic      wrAlias;    // also write aggressor cell
    logic      rdMain;     // accepted read
    logic      rdHold;     // read keeps previous output
    logic      rdZero;     // read returns 0
    logic      rdAnd;      // read ANDs with aggressor cell
    logic      rdDisturb;  // invert victim after this read
    logic      rstPreset;  // victim gets presetVal in reset
    logic      presetVal;
    cellMode_e cellMode;
    logic      forceVal;
    logic      trigLevel;
  } strobe_t;

  function automatic faultKind_e decodeKind(input logic [3:0] code);
    case (code)
      4'd1:    return FK_STUCK;
      4'd2:    return FK_TRANS;
      4'd3:    return FK_OPEN;
      4'd4:    return FK_STATE;
      4'd5:    return FK_INV;
      4'd6:    return FK_IDEM;
      4'd7:    return FK_RDIST;
      4'd8:    return FK_ANONE;
      4'd9:    return FK_ALIAS;
      default: return FK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fault_ram_ctrl.sv
module fault_ram_ctrl
  import fault_ram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        faultSel,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic [ADDR_W-1:0] aggrAddr,
  input  logic [1:0]        faultPol,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] vicSel,
  output logic [ADDR_W-1:0] aggSel
);

  faultKind_e        cfgKind;
  logic [ADDR_W-1:0] cfgVic;
  logic [ADDR_W-1:0] cfgAgg;
  logic [1:0]        cfgPol;
  faultKind_e        inKind;
  logic              victimHit;
  logic              runRd;
  logic              runWr;

  assign inKind = decodeKind(faultSel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgKind <= inKind;
      cfgVic  <= victimAddr;
      cfgAgg  <= aggrAddr;
      cfgPol  <= faultPol;
    end
  end

  // During reset the live inputs steer the victim preset
  assign vicSel    = rst ? victimAddr : cfgVic;
  assign aggSel    = cfgAgg;
  assign victimHit = (addr == cfgVic);
  assign runWr     = we && !rst;
  assign runRd     = re && !we && !rst;

  always_comb begin
    strb = '0;
    strb.wrMain    = runWr && !(victimHit && (cfgKind == FK_OPEN || cfgKind == FK_ANONE));
    strb.wrAlias   = runWr && victimHit && (cfgKind == FK_ALIAS);
    strb.rdMain    = runRd;
    strb.rdHold    = runRd && victimHit && (cfgKind == FK_OPEN);
    strb.rdZero    = victimHit && (cfgKind == FK_ANONE);
    strb.rdAnd     = victimHit && (cfgKind == FK_ALIAS);
    strb.rdDisturb = runRd && victimHit && (cfgKind == FK_RDIST);
    strb.rstPreset = (inKind == FK_STUCK) || (inKind == FK_STATE && !faultPol[1]);
    strb.presetVal = faultPol[0];
    strb.forceVal  = cfgPol[0];
    strb.trigLevel = cfgPol[1];
    case (cfgKind)
      FK_STUCK: strb.cellMode = CM_STUCK;
      FK_TRANS: strb.cellMode = CM_TRANS;
      FK_STATE: strb.cellMode = CM_STATE;
      FK_INV:   strb.cellMode = CM_INV;
      FK_IDEM:  strb.cellMode = CM_IDEM;
      default:  strb.cellMode = CM_NONE;
    endcase
  end

endmodule

// File: rtl/fault_ram_dp.sv
module fault_ram_dp
  import fault_ram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrData,
  input  logic [ADDR_W-1:0] vicSel,
  input  logic [ADDR_W-1:0] aggSel,
  output logic              rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] cells;
  logic [DEPTH-1:0] rawNext;
  logic [DEPTH-1:0] cellNext;
  logic [DEPTH-1:0] presetVec;
  logic             aggCur;
  logic             aggNew;
  logic             vicCur;
  logic             vicRaw;
  logic             vicNext;
  logic             trig;
  logic             vicTouched;
  logic             rdValue;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cell
      localparam logic [ADDR_W-1:0] IDX = ADDR_W'(gi);
      assign rawNext[gi]   = ((strb.wrMain && addr == IDX) || (strb.wrAlias && aggSel == IDX))
                             ? wrData : cells[gi];
      assign cellNext[gi]  = (vicTouched && vicSel == IDX) ? vicNext : rawNext[gi];
      assign presetVec[gi] = strb.rstPreset && (vicSel == IDX) && strb.presetVal;
    end
  endgenerate

  assign aggCur     = cells[aggSel];
  assign aggNew     = rawNext[aggSel];
  assign vicCur     = cells[vicSel];
  assign vicRaw     = rawNext[vicSel];
  assign trig       = (aggCur != aggNew) && (aggNew == strb.trigLevel);
  assign vicTouched = (strb.cellMode != CM_NONE) || strb.rdDisturb;

  always_comb begin
    case (strb.cellMode)
      CM_STUCK: vicNext = strb.forceVal;
      CM_TRANS: vicNext = (vicRaw != vicCur && vicRaw == strb.forceVal) ? vicCur : vicRaw;
      CM_STATE: vicNext = (aggNew == strb.trigLevel) ? strb.forceVal : vicRaw;
      CM_INV:   vicNext = trig ? ~vicRaw : vicRaw;
      CM_IDEM:  vicNext = trig ? strb.forceVal : vicRaw;
      default:  vicNext = strb.rdDisturb ? ~vicCur : vicRaw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cells <= presetVec;
    else     cells <= cellNext;
  end

  always_comb begin
    if (strb.rdZero)     rdValue = 1'b0;
    else if (strb.rdAnd) rdValue = cells[addr] & cells[aggSel];
    else                 rdValue = cells[addr];
  end

  always_ff @(posedge clk) begin
    if (rst)                                rdData <= 1'b0;
    else if (strb.rdMain && !strb.rdHold)   rdData <= rdValue;
  end

endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fault_ram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic              wrData,
  output logic              rdData,
  input  logic [3:0]        faultSel,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic [ADDR_W-1:0] aggrAddr,
  input  logic [1:0]        faultPol
);

  strobe_t           strb;
  logic [ADDR_W-1:0] vicSel;
  logic [ADDR_W-1:0] aggSel;

  fault_ram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(we), .re(re), .addr(addr),
    .faultSel(faultSel), .victimAddr(victimAddr), .aggrAddr(aggrAddr),
    .faultPol(faultPol), .strb(strb), .vicSel(vicSel), .aggSel(aggSel)
  );

  fault_ram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .addr(addr), .wrData(wrData),
    .vicSel(vicSel), .aggSel(aggSel), .rdData(rdData)
  );

endmodule

// File: rtl/fault_ram_chk.sv
module fault_ram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic              re,
  input logic              rdData,
  input logic [3:0]        faultSel,
  input logic [ADDR_W-1:0] victimAddr,
  input logic [1:0]        faultPol
);

  logic [3:0]        seenSel;
  logic [ADDR_W-1:0] seenVic;
  logic [1:0]        seenPol;
  logic              vicRead;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenSel <= faultSel;
      seenVic <= victimAddr;
      seenPol <= faultPol;
    end
  end

  assign vicRead = re && !we && (addr == seenVic);

  assert_rd_stable_R1: assert property (@(posedge clk) disable iff (rst)
    !(re && !we) |=> $stable(rdData));

  assert_stuck_value_R3: assert property (@(posedge clk) disable iff (rst)
    (seenSel == 4'd1 && vicRead) |=> (rdData == seenPol[0]));

  assert_open_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (seenSel == 4'd3 && vicRead) |=> $stable(rdData));

  assert_nocell_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (seenSel == 4'd8 && vicRead) |=> (rdData == 1'b0));

endmodule

bind fault_ram fault_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .we(we), .re(re), .rdData(rdData),
  .faultSel(faultSel), .victimAddr(victimAddr), .faultPol(faultPol)
);

// File: tb/tb_fault_ram.sv
module tb_fault_ram;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic              re = 1'b0;
  logic              wrData = 1'b0;
  logic              rdData;
  logic [3:0]        faultSel = '0;
  logic [ADDR_W-1:0] victimAddr = '0;
  logic [ADDR_W-1:0] aggrAddr = '0;
  logic [1:0]        faultPol = '0;

  int    checks = 0;
  int    errors = 0;
  bit    reLast = 1'b0;
  bit    expQ[$];
  string tagQ[$];

  fault_ram #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .re(re), .wrData(wrData),
    .rdData(rdData), .faultSel(faultSel), .victimAddr(victimAddr),
    .aggrAddr(aggrAddr), .faultPol(faultPol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: compare registered read data one cycle after each accepted read
  always @(posedge clk) reLast <= re && !we && !rst;

  always @(negedge clk) begin
    if (reLast) begin
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read result with no expected item, actual %0b expected none", rdData);
      end else begin
        bit    e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s: rdData actual %0b expected %0b", t, rdData, e);
        end
      end
    end
  end

  task automatic checkNow(input bit actual, input bit expected, input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, actual, expected);
    end
  endtask

  task automatic opWrite(input int a, input bit d);
    addr = ADDR_W'(a); wrData = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic opRead(input int a, input bit expected, input string tag);
    addr = ADDR_W'(a); re = 1'b1;
    expQ.push_back(expected);
    tagQ.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic opBoth(input int a, input bit d);
    addr = ADDR_W'(a); wrData = d; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
  endtask

  // After reset the fault inputs change to a stuck-at-0 on cell 0 (R12)
  task automatic applyReset(input int sel, input int vic, input int agg, input int pol);
    rst = 1'b1;
    faultSel = 4'(sel); victimAddr = ADDR_W'(vic); aggrAddr = ADDR_W'(agg); faultPol = 2'(pol);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    faultSel = 4'd1; victimAddr = '0; aggrAddr = 6'd1; faultPol = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    checkNow(rdData, 1'b0, "R1 rdData in reset");
    applyReset(0, 0, 0, 0);
    checkNow(rdData, 1'b0, "R1 rdData after reset");
    opRead(5, 1'b0, "R1 cleared cell");
    @(negedge clk);
    checkNow(rdData, 1'b0, "R1 hold without read");

    // R2 healthy memory, pattern
    for (int i = 0; i < DEPTH; i++) opWrite(i, bit'(i[0] ^ i[3]));
    for (int i = DEPTH - 1; i >= 0; i--) opRead(i, bit'(i[0] ^ i[3]), "R2 pattern");
    opRead(1, 1'b1, "R2 setup");
    opBoth(2, 1'b1);
    checkNow(rdData, 1'b1, "R2 dropped read");
    opRead(2, 1'b1, "R2 write in combined cycle");
    // R12: post-reset inputs request SA0 on cell 0, must be ignored
    opWrite(0, 1'b1);
    opRead(0, 1'b1, "R12 late config ignored");

    // R3 stuck-at 1 and stuck-at 0
    applyReset(1, 10, 0, 2'b01);
    opRead(10, 1'b1, "R3 SA1 after reset");
    opWrite(10, 1'b0);
    opRead(10, 1'b1, "R3 SA1 after write 0");
    opWrite(11, 1'b0);
    opRead(11, 1'b0, "R3 neighbour");
    applyReset(1, 10, 0, 2'b00);
    opWrite(10, 1'b1);
    opRead(10, 1'b0, "R3 SA0 after write 1");

    // R4 transition faults
    applyReset(2, 20, 0, 2'b01);
    opWrite(20, 1'b1);
    opRead(20, 1'b0, "R4 rise blocked");
    applyReset(2, 20, 0, 2'b00);
    opWrite(20, 1'b1);
    opRead(20, 1'b1, "R4 rise allowed");
    opWrite(20, 1'b0);
    opRead(20, 1'b1, "R4 fall blocked");

    // R5 stuck-open
    applyReset(3, 30, 0, 2'b00);
    opWrite(31, 1'b1);
    opRead(31, 1'b1, "R5 setup");
    opWrite(30, 1'b0);
    opRead(30, 1'b1, "R5 returns previous read");
    opWrite(31, 1'b0);
    opRead(31, 1'b0, "R5 setup 2");
    opWrite(30, 1'b1);
    opRead(30, 1'b0, "R5 write ignored");

    // R6 state coupling
    applyReset(4, 40, 41, 2'b01);
    opRead(40, 1'b1, "R6 forced from reset");
    opWrite(41, 1'b1);
    opWrite(40, 1'b0);
    opRead(40, 1'b0, "R6 released");
    opWrite(41, 1'b0);
    opRead(40, 1'b1, "R6 forced again");
    applyReset(4, 40, 41, 2'b10);
    opWrite(40, 1'b1);
    opRead(40, 1'b1, "R6 not forced");
    opWrite(41, 1'b1);
    opRead(40, 1'b0, "R6 aggressor state 1");
    opWrite(40, 1'b1);
    opRead(40, 1'b0, "R6 held while state");

    // R7 inversion coupling, trigger on rise
    applyReset(5, 50, 3, 2'b10);
    opWrite(3, 1'b1);
    opRead(50, 1'b1, "R7 rise inverts");
    opWrite(3, 1'b1);
    opRead(50, 1'b1, "R7 no transition");
    opWrite(3, 1'b0);
    opRead(50, 1'b1, "R7 fall ignored");
    opWrite(3, 1'b1);
    opRead(50, 1'b0, "R7 second rise");

    // R8 idempotent coupling, trigger on fall, force 1
    applyReset(6, 5, 60, 2'b01);
    opWrite(60, 1'b1);
    opRead(5, 1'b0, "R8 rise ignored");
    opWrite(60, 1'b0);
    opRead(5, 1'b1, "R8 fall forces");
    opWrite(5, 1'b0);
    opWrite(60, 1'b0);
    opRead(5, 1'b0, "R8 no transition");

    // R9 read disturb
    applyReset(7, 12, 0, 2'b00);
    opWrite(12, 1'b1);
    opRead(12, 1'b1, "R9 first read");
    opRead(12, 1'b0, "R9 flipped");
    opRead(12, 1'b1, "R9 flipped back");
    opRead(13, 1'b0, "R9 neighbour");

    // R10 decoder selects no cell
    applyReset(8, 33, 0, 2'b00);
    opWrite(34, 1'b1);
    opWrite(33, 1'b1);
    opRead(34, 1'b1, "R10 setup");
    opRead(33, 1'b0, "R10 reads zero");

    // R11 decoder selects two cells
    applyReset(9, 9, 17, 2'b00);
    opWrite(9, 1'b1);
    opRead(17, 1'b1, "R11 second cell written");
    opRead(9, 1'b1, "R11 AND of ones");
    opWrite(17, 1'b0);
    opRead(9, 1'b0, "R11 AND with zero");
    opRead(17, 1'b0, "R11 aggressor alone");
    opWrite(17, 1'b1);
    opRead(9, 1'b1, "R11 restored");

    @(negedge clk);
    @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expected reads left, expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule